// File: doc/BRIEF.md
# Integer Add/Subtract Datapath with Carry, Overflow and Condition Flags

This block is the arithmetic core behind every add, subtract, negate, extended-precision and immediate-add operation of a 64-bit integer pipeline. A decoder supplies a class code and the two per-operation option bits: overflow-enable and record. The block picks a first operand, a second operand and a carry-in from the register values, the 16-bit immediate, the next-instruction address and the stored status bits. It then forms the single sum `first + second + carry_in` at 65 bits.

From that sum it derives the 64-bit result, carry and signed overflow at both 64-bit and 32-bit width, and the new values of the carry, carry-32, overflow, overflow-32 and sticky summary-overflow status bits, each with its own write enable. For record operations it also builds a 4-bit condition field. A mode input chooses which width feeds the primary carry and overflow bits and the condition field. The block is purely combinational. The status bits it does not update are passed through unchanged.

Top module: `addsub_flags`

## Requirements
- R1: First operand by class code: 0 add, 4 add-carrying, 5 add-immediate-carrying, 6 add-extended, 7 add-minus-one, 8 add-zero and 16 add-alt-extended use `ra_val`. 1 add-immediate and 2 add-immediate-shifted use zero when `ra_is_r0` is 1, otherwise `ra_val`. 3 add-to-address uses `nia`. 9 subtract-from, 10 subtract-carrying, 11 subtract-immediate, 12 subtract-extended, 13 subtract-minus-one, 14 subtract-zero and 15 negate use `~ra_val`.
- R2: Second operand: classes 1, 5 and 11 use `imm` sign-extended. Classes 2 and 3 use `imm` shifted left by 16 with zero fill, then sign-extended. Classes 0, 4, 6, 9, 10, 12 and 16 use `rb_val`. Classes 7 and 13 use all ones. Classes 8, 14 and 15 use zero.
- R3: Carry-in is 0 for classes 0 to 5, 1 for classes 9, 10, 11 and 15, `ca_in` for classes 6, 7, 8, 12, 13 and 14, and `ov_in` for class 16.
- R4: `result` is the low 64 bits of the sum. `ca64` is the carry out of bit 63, and `ca32` is the carry into bit 32. `ov64` and `ov32` are the signed overflows of the 64-bit and low 32-bit additions.
- R5: For carrying classes (4, 5, 6, 7, 8, 10, 11, 12, 13, 14), `ca_we` and `ca32_we` are 1. `ca_out` is `ca64` when `mode64` is 1 and `ca32` otherwise, and `ca32_out` is `ca32`.
- R6: A status bit whose write enable is 0 leaves the block equal to its input: `ca_out`=`ca_in`, `ca32_out`=`ca32_in`, `ov_out`=`ov_in`, `ov32_out`=`ov32_in` and `so_out`=`so_in`.
- R7: With `ov_en` set on classes 0, 4, 6 to 10 or 12 to 15, `ov_we` and `ov32_we` are 1. `ov_out` is the overflow of the selected width, and `ov32_out` is `ov32`. `so_we` equals the new `ov_out`, and `so_out` becomes 1 when `so_we` is 1. `ov_en` has no effect on classes 1, 2, 3, 5, 11 and 16.
- R8: Class 16 writes its carry into the overflow fields instead: `ov_we`=`ov32_we`=1, `ov_out` is the carry of the selected width and `ov32_out`=`ca32`. It does not write the carry bits or `so`.
- R9: With `record` set on classes 0, 4, 5, 6 to 10 or 12 to 15, `cr_we`=1. `cr_field` is {LT,GT,EQ,SO} in bits 3..0. LT is the sign bit of the result at the selected width, and EQ means the result is zero at that width. GT is set when neither LT nor EQ is set, and SO equals `so_out`.
- R10: `record` has no effect (`cr_we`=0) on classes 1, 2, 3, 11 and 16.
- R11: Class codes 17 to 31 are undefined. They add `ra_val`, `rb_val` and 0 and assert no write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 5 | Operation class code |
| ra_is_r0 | input | 1 | Register-A field is zero |
| ra_val | input | 64 | Register A value |
| rb_val | input | 64 | Register B value |
| imm | input | 16 | Signed immediate |
| nia | input | 64 | Next-instruction address |
| mode64 | input | 1 | 1 selects 64-bit flags, 0 selects 32-bit flags |
| ov_en | input | 1 | Overflow-enable option |
| record | input | 1 | Record option |
| ca_in | input | 1 | Stored carry |
| ca32_in | input | 1 | Stored carry-32 |
| ov_in | input | 1 | Stored overflow |
| ov32_in | input | 1 | Stored overflow-32 |
| so_in | input | 1 | Stored summary overflow |
| result | output | 64 | Sum |
| ca64 | output | 1 | Raw 64-bit carry |
| ca32 | output | 1 | Raw 32-bit carry |
| ov64 | output | 1 | Raw 64-bit overflow |
| ov32 | output | 1 | Raw 32-bit overflow |
| ca_out | output | 1 | New carry |
| ca32_out | output | 1 | New carry-32 |
| ov_out | output | 1 | New overflow |
| ov32_out | output | 1 | New overflow-32 |
| so_out | output | 1 | New summary overflow |
| ca_we | output | 1 | Carry write enable |
| ca32_we | output | 1 | Carry-32 write enable |
| ov_we | output | 1 | Overflow write enable |
| ov32_we | output | 1 | Overflow-32 write enable |
| so_we | output | 1 | Summary-overflow write enable |
| cr_we | output | 1 | Condition-field write enable |
| cr_field | output | 4 | {LT,GT,EQ,SO} |

## Verification
The block holds no state, so any wrong internal choice shows at the ports at once, for the same input word. A wrong operand or carry-in selection corrupts `result` and the raw flags for that vector. A wrong class-to-enable decode appears as a write enable in the wrong state, or as a passed-through status bit that differs from its input. Width-selection faults show only when the 32-bit and 64-bit flags disagree. The vectors therefore straddle bit 31/32, the most negative values and all-ones operands in both modes.

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int XLEN = 64,
  parameter int HALF = 32,
  parameter int IMMW = 16,
  parameter int OPW  = 5
) (
  input  logic [4:0]  op,
  input  logic        ra_is_r0,
  input  logic [63:0] ra_val,
  input  logic [63:0] rb_val,
  input  logic [15:0] imm,
  input  logic [63:0] nia,
  input  logic        mode64,
  input  logic        ov_en,
  input  logic        record,
  input  logic        ca_in,
  input  logic        ca32_in,
  input  logic        ov_in,
  input  logic        ov32_in,
  input  logic        so_in,
  output logic [63:0] result,
  output logic        ca64,
  output logic        ca32,
  output logic        ov64,
  output logic        ov32,
  output logic        ca_out,
  output logic        ca32_out,
  output logic        ov_out,
  output logic        ov32_out,
  output logic        so_out,
  output logic        ca_we,
  output logic        ca32_we,
  output logic        ov_we,
  output logic        ov32_we,
  output logic        so_we,
  output logic        cr_we,
  output logic [3:0]  cr_field
);
  localparam int HIPAD = XLEN - 2 * IMMW;

  logic [XLEN-1:0] simm, simm_hi, opa, opb;
  logic [XLEN:0]   sum;
  logic cin, wr_ca, ov_ok, rc_ok, alt;
  logic cy_sel, ov_sel, ov_wr, lt, eq;

  assign simm    = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  assign simm_hi = {{HIPAD{imm[IMMW-1]}}, imm, {IMMW{1'b0}}};

  always_comb begin
    opa = ra_val; opb = rb_val; cin = 1'b0;
    wr_ca = 1'b0; ov_ok = 1'b0; rc_ok = 1'b0; alt = 1'b0;
    case (op)
      5'd0:  begin ov_ok = 1'b1; rc_ok = 1'b1; end
      5'd1:  begin opa = ra_is_r0 ? '0 : ra_val; opb = simm; end
      5'd2:  begin opa = ra_is_r0 ? '0 : ra_val; opb = simm_hi; end
      5'd3:  begin opa = nia; opb = simm_hi; end
      5'd4:  begin wr_ca = 1'b1; ov_ok = 1'b1; rc_ok = 1'b1; end
      5'd5:  begin opb = simm; wr_ca = 1'b1; rc_ok = 1'b1; end
      5'd6:  begin cin = ca_in; wr_ca = 1'b1; ov_ok = 1'b1; rc_ok = 1'b1; end
      5'd7:  begin opb = '1; cin = ca_in; wr_ca = 1'b1; ov_ok = 1'b1; rc_ok = 1'b1; end
      5'd8:  begin opb = '0; cin = ca_in; wr_ca = 1'b1; ov_ok = 1'b1; rc_ok = 1'b1; end
      5'd9:  begin opa = ~ra_val; cin = 1'b1; ov_ok = 1'b1; rc_ok = 1'b1; end
      5'd10: begin opa = ~ra_val; cin = 1'b1; wr_ca = 1'b1; ov_ok = 1'b1; rc_ok = 1'b1; end
      5'd11: begin opa = ~ra_val; opb = simm; cin = 1'b1; wr_ca = 1'b1; end
      5'd12: begin opa = ~ra_val; cin = ca_in; wr_ca = 1'b1; ov_ok = 1'b1; rc_ok = 1'b1; end
      5'd13: begin opa = ~ra_val; opb = '1; cin = ca_in; wr_ca = 1'b1; ov_ok = 1'b1; rc_ok = 1'b1; end
      5'd14: begin opa = ~ra_val; opb = '0; cin = ca_in; wr_ca = 1'b1; ov_ok = 1'b1; rc_ok = 1'b1; end
      5'd15: begin opa = ~ra_val; opb = '0; cin = 1'b1; ov_ok = 1'b1; rc_ok = 1'b1; end
      5'd16: begin cin = ov_in; alt = 1'b1; end
      default: ;
    endcase
  end

  assign sum    = {1'b0, opa} + {1'b0, opb} + {{XLEN{1'b0}}, cin};
  assign result = sum[XLEN-1:0];
  assign ca64   = sum[XLEN];
  assign ca32   = sum[HALF] ^ opa[HALF] ^ opb[HALF];
  assign ov64   = (ca64 ^ sum[XLEN-1]) & ~(opa[XLEN-1] ^ opb[XLEN-1]);
  assign ov32   = (ca32 ^ sum[HALF-1]) & ~(opa[HALF-1] ^ opb[HALF-1]);

  assign cy_sel = mode64 ? ca64 : ca32;
  assign ov_sel = mode64 ? ov64 : ov32;
  assign ov_wr  = ov_ok & ov_en;

  assign ca_we    = wr_ca;
  assign ca32_we  = wr_ca;
  assign ov_we    = ov_wr | alt;
  assign ov32_we  = ov_wr | alt;
  assign ca_out   = wr_ca ? cy_sel : ca_in;
  assign ca32_out = wr_ca ? ca32 : ca32_in;
  assign ov_out   = ov_wr ? ov_sel : (alt ? cy_sel : ov_in);
  assign ov32_out = ov_wr ? ov32 : (alt ? ca32 : ov32_in);
  assign so_we    = ov_wr & ov_sel;
  assign so_out   = so_we | so_in;

  assign lt       = mode64 ? result[XLEN-1] : result[HALF-1];
  assign eq       = mode64 ? ~|result : ~|result[HALF-1:0];
  assign cr_we    = rc_ok & record;
  assign cr_field = {lt, ~(lt | eq), eq, so_out};
endmodule

// File: rtl/addsub_flags_chk.sv
module addsub_flags_chk (
  input logic        mode64,
  input logic        ca_in,
  input logic        ca32_in,
  input logic        ov_in,
  input logic        ov32_in,
  input logic        so_in,
  input logic        ca64,
  input logic        ca_out,
  input logic        ca32_out,
  input logic        ov_out,
  input logic        ov32_out,
  input logic        so_out,
  input logic        ca_we,
  input logic        ov_we,
  input logic        so_we,
  input logic        cr_we,
  input logic [3:0]  cr_field
);
  always_comb begin
    // R6
    keep_ca_chk: assert (ca_we || (ca_out == ca_in && ca32_out == ca32_in))
      else $error("carry bits changed without enable");
    // R6
    keep_ov_chk: assert (ov_we || (ov_out == ov_in && ov32_out == ov32_in))
      else $error("overflow bits changed without enable");
    // R7
    so_sticky_chk: assert (!so_in || so_out)
      else $error("summary overflow cleared");
    // R7
    so_set_chk: assert (!so_we || (so_out && ov_out))
      else $error("summary overflow write without overflow");
    // R9
    cr_shape_chk: assert (!cr_we || ($onehot(cr_field[3:1]) && cr_field[0] == so_out))
      else $error("malformed condition field");
    // R5
    ca_width_chk: assert (!ca_we || mode64 || ca_out == ca32_out)
      else $error("32-bit mode carry mismatch");
    // R5
    ca_wide_chk: assert (!ca_we || !mode64 || ca_out == ca64)
      else $error("64-bit mode carry mismatch");
  end
endmodule

bind addsub_flags addsub_flags_chk chk_i (
  .mode64(mode64), .ca_in(ca_in), .ca32_in(ca32_in), .ov_in(ov_in),
  .ov32_in(ov32_in), .so_in(so_in), .ca64(ca64), .ca_out(ca_out),
  .ca32_out(ca32_out), .ov_out(ov_out), .ov32_out(ov32_out),
  .so_out(so_out), .ca_we(ca_we), .ov_we(ov_we), .so_we(so_we),
  .cr_we(cr_we), .cr_field(cr_field)
);

// File: tb/addsub_flags_tb.sv
module addsub_flags_tb_top;
  typedef struct packed {
    logic [4:0]  op;
    logic [63:0] ra, rb;
    logic [15:0] imm;
    logic [63:0] nia;
    logic rz, m64, ca, ca32, ov, ov32, so, rc, oe;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{5'd0,  64'h0000_0000_FFFF_FFFF, 64'h1, 16'h0, 64'h0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1},
    '{5'd1,  64'h10, 64'h0, 16'hFFFF, 64'h0, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{5'd2,  64'h5, 64'h0, 16'h7FFF, 64'h0, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{5'd3,  64'h0, 64'h0, 16'hFFFE, 64'h0000_0000_0001_0000, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{5'd4,  64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 16'h0, 64'h0, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1},
    '{5'd5,  64'h7FFF_FFFF, 64'h0, 16'h0001, 64'h0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0},
    '{5'd6,  64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 16'h0, 64'h0, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1},
    '{5'd7,  64'h0, 64'h0, 16'h0, 64'h0, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1},
    '{5'd8,  64'hFFFF_FFFF, 64'h0, 16'h0, 64'h0, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1},
    '{5'd9,  64'h9, 64'h4, 16'h0, 64'h0, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1},
    '{5'd10, 64'h8000_0000, 64'h0, 16'h0, 64'h0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1},
    '{5'd11, 64'h3, 64'h0, 16'h0002, 64'h0, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{5'd13, 64'h1, 64'h0, 16'h0, 64'h0, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1},
    '{5'd14, 64'h0, 64'h0, 16'h0, 64'h0, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  vec_t v;
  logic [63:0] result;
  logic ca64, ca32, ov64, ov32, ca_out, ca32_out, ov_out, ov32_out, so_out;
  logic ca_we, ca32_we, ov_we, ov32_we, so_we, cr_we;
  logic [3:0] cr_field;
  int nchk = 0, nbad = 0, cyc = 0;
  logic done = 1'b0;

  addsub_flags dut_i (
    .op(v.op), .ra_is_r0(v.rz), .ra_val(v.ra), .rb_val(v.rb), .imm(v.imm),
    .nia(v.nia), .mode64(v.m64), .ov_en(v.oe), .record(v.rc),
    .ca_in(v.ca), .ca32_in(v.ca32), .ov_in(v.ov), .ov32_in(v.ov32), .so_in(v.so),
    .result(result), .ca64(ca64), .ca32(ca32), .ov64(ov64), .ov32(ov32),
    .ca_out(ca_out), .ca32_out(ca32_out), .ov_out(ov_out), .ov32_out(ov32_out),
    .so_out(so_out), .ca_we(ca_we), .ca32_we(ca32_we), .ov_we(ov_we),
    .ov32_we(ov32_we), .so_we(so_we), .cr_we(cr_we), .cr_field(cr_field)
  );

  function automatic logic [82:0] model(vec_t x);
    logic [63:0] a, b, r, sx, sh;
    logic c, c64, c32, o64, o32, wca, ook, rok, alt, ow, ovs, cys, l, e, sw, so;
    logic [64:0] s;
    logic [32:0] lo;
    sx = 64'(signed'(x.imm));
    sh = sx << 16;
    a = x.ra; b = x.rb; c = 0; wca = 0; ook = 0; rok = 0; alt = 0;
    if (x.op inside {5'd1, 5'd2} && x.rz) a = 0;
    if (x.op == 5'd3) a = x.nia;
    if (x.op inside {[5'd9:5'd15]}) a = ~x.ra;
    if (x.op inside {5'd1, 5'd5, 5'd11}) b = sx;
    if (x.op inside {5'd2, 5'd3}) b = sh;
    if (x.op inside {5'd7, 5'd13}) b = '1;
    if (x.op inside {5'd8, 5'd14, 5'd15}) b = 0;
    if (x.op inside {5'd9, 5'd10, 5'd11, 5'd15}) c = 1;
    if (x.op inside {5'd6, 5'd7, 5'd8, 5'd12, 5'd13, 5'd14}) c = x.ca;
    if (x.op == 5'd16) begin c = x.ov; alt = 1; end
    wca = x.op inside {5'd4, 5'd5, 5'd6, 5'd7, 5'd8, [5'd10:5'd14]};
    ook = x.op inside {5'd0, 5'd4, [5'd6:5'd10], [5'd12:5'd15]};
    rok = ook || x.op == 5'd5;
    s = 65'(a) + 65'(b) + 65'(c);
    r = s[63:0];
    lo = 33'(a[31:0]) + 33'(b[31:0]) + 33'(c);
    c64 = s[64]; c32 = lo[32];
    o64 = (a[63] == b[63]) && (r[63] != a[63]);
    o32 = (a[31] == b[31]) && (r[31] != a[31]);
    cys = x.m64 ? c64 : c32;
    ovs = x.m64 ? o64 : o32;
    ow = ook && x.oe;
    sw = ow && ovs;
    so = x.so || sw;
    l = x.m64 ? r[63] : r[31];
    e = x.m64 ? (r == 0) : (r[31:0] == 0);
    return {r, c64, c32, o64, o32,
            wca ? cys : x.ca, wca ? c32 : x.ca32,
            ow ? ovs : (alt ? cys : x.ov), ow ? o32 : (alt ? c32 : x.ov32), so,
            wca, wca, ow || alt, ow || alt, sw, rok && x.rc,
            l, !l && !e, e, so};
  endfunction

  function automatic logic [82:0] actual();
    return {result, ca64, ca32, ov64, ov32, ca_out, ca32_out, ov_out, ov32_out, so_out,
            ca_we, ca32_we, ov_we, ov32_we, so_we, cr_we, cr_field};
  endfunction

  task automatic apply(vec_t x, string tag);
    logic [82:0] exp;
    @(posedge clk);
    v = x;
    @(negedge clk);
    exp = model(x);
    nchk++;
    if (actual() !== exp) begin
      nbad++;
      $display("FAIL %s op=%0d actual=%h expected=%h", tag, x.op, actual(), exp);
    end
  endtask

  task automatic lit(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      nbad++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    vec_t t;
    v = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    lit("R6 reset result", result, 64'h0);
    lit("R6 reset enables", {58'h0, ca_we, ca32_we, ov_we, ov32_we, so_we, cr_we}, 64'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) apply(TBL[i], "R4 table");

    // R1
    t = '0; t.op = 5'd1; t.rz = 1; t.ra = 64'h1234; t.imm = 16'h5; apply(t, "R1");
    lit("R1 zero base", result, 64'h5);
    t = '0; t.op = 5'd3; t.nia = 64'h1000; t.imm = 16'h1; apply(t, "R1");
    lit("R1 address base", result, 64'h11000);
    // R2
    t = '0; t.op = 5'd2; t.rz = 1; t.ra = 64'h77; t.imm = 16'h8000; apply(t, "R2");
    lit("R2 shifted imm", result, 64'hFFFF_FFFF_8000_0000);
    t = '0; t.op = 5'd7; t.m64 = 1; apply(t, "R2");
    lit("R2 minus one", result, 64'hFFFF_FFFF_FFFF_FFFF);
    // R3
    t = '0; t.op = 5'd12; t.ra = 5; t.rb = 9; t.ca = 1; t.m64 = 1; apply(t, "R3");
    lit("R3 extended sub ca=1", result, 64'h4);
    t.ca = 0; apply(t, "R3");
    lit("R3 extended sub ca=0", result, 64'h3);
    t = '0; t.op = 5'd16; t.ra = 1; t.rb = 1; t.ov = 1; apply(t, "R3");
    lit("R3 alt carry-in", result, 64'h3);
    // R4 most negative
    t = '0; t.op = 5'd0; t.m64 = 1; t.ra = 64'h8000_0000_0000_0000; t.rb = t.ra; apply(t, "R4");
    lit("R4 min+min flags", {60'h0, ca64, ov64, result == 0, 1'b1}, 64'hF);
    // R5 32-bit boundary
    t = '0; t.op = 5'd4; t.ra = 64'hFFFF_FFFF; t.rb = 1; apply(t, "R5");
    lit("R5 mode32 carry", {62'h0, ca_out, ca64}, 64'h2);
    t.m64 = 1; apply(t, "R5");
    lit("R5 mode64 carry", {62'h0, ca_out, ca32_out}, 64'h1);
    // R6
    t = '0; t.op = 5'd0; t.ca = 1; t.ov32 = 1; t.ra = 64'hFFFF_FFFF_FFFF_FFFF; t.rb = 1; t.m64 = 1;
    apply(t, "R6");
    lit("R6 keep", {60'h0, ca_out, ca32_out, ov_out, ov32_out}, 64'h9);
    // R7
    t = '0; t.op = 5'd15; t.m64 = 1; t.oe = 1; t.rc = 1; t.ra = 64'h8000_0000_0000_0000; apply(t, "R7");
    lit("R7 negate min", {61'h0, ov_out, so_we, cr_field[0]}, 64'h7);
    t = '0; t.op = 5'd0; t.oe = 1; t.so = 1; t.ra = 1; t.rb = 2; apply(t, "R7");
    lit("R7 sticky", {62'h0, so_out, so_we}, 64'h2);
    t = '0; t.op = 5'd5; t.oe = 1; t.m64 = 1; t.ra = 64'h7FFF_FFFF_FFFF_FFFF; t.imm = 1; apply(t, "R7");
    lit("R7 oe ignored", {62'h0, ov_we, ov_out}, 64'h0);
    // R8
    t = '0; t.op = 5'd16; t.m64 = 1; t.ra = '1; t.rb = 1; t.ca = 1; apply(t, "R8");
    lit("R8 carry to ov", {60'h0, ov_out, ca_we, ca_out, so_we}, 64'hA);
    // R9
    t = '0; t.op = 5'd9; t.rc = 1; t.m64 = 1; t.ra = 7; t.rb = 7; apply(t, "R9");
    lit("R9 eq", {60'h0, cr_field}, 64'h2);
    t.rb = 3; apply(t, "R9");
    lit("R9 lt", {60'h0, cr_field}, 64'h8);
    t.rb = 9; apply(t, "R9");
    lit("R9 gt", {60'h0, cr_field}, 64'h4);
    t = '0; t.op = 5'd0; t.rc = 1; t.ra = 64'hFFFF_FFFF; t.rb = 1; apply(t, "R9");
    lit("R9 mode32 eq", {60'h0, cr_field}, 64'h2);
    // R10
    t = '0; t.op = 5'd1; t.rc = 1; t.ra = 3; apply(t, "R10");
    lit("R10 no record", {63'h0, cr_we}, 64'h0);
    // R11
    t = '0; t.op = 5'd20; t.rc = 1; t.oe = 1; t.ra = 64'hFFFF_FFFF_FFFF_FFFF; t.rb = 2; t.ca = 1;
    apply(t, "R11");
    lit("R11 undefined", {result[57:0], ca_we, ca32_we, ov_we, ov32_we, so_we, cr_we}, {58'h1, 6'h0});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule